// File: doc/BRIEF.md
# Successive-Approximation Oscillator Coarse Tuner

This block sets the coarse control word of a digitally controlled oscillator before the loop settles into continuous tracking. It runs a binary search: the word starts at mid-scale, and for each trial the block raises a restart signal that stops the oscillator and reference paths. It then lowers the restart and waits for one early/late verdict from the phase detector. A "slow" verdict moves the word up by the current step and a "fast" verdict moves it down. The steps halve from a quarter of full scale to one, and a final step of one is applied a second time.

The restart pulse lasts a number of clock cycles taken from an input, with a floor of two cycles. When the last step has been applied, the block stops issuing restarts and raises a flag that hands the oscillator to fine tuning. The word is then frozen. A start input launches the search again from mid-scale at any time, including during a search or after the hand-off. The word saturates at the ends of its range instead of wrapping.

Top module: `cs_coarse_tuner`

## Requirements
- R1: After reset, coarse_word is 128 (mid-scale), restart_out is 0 and fine_mode is 0, and the block waits for search_start.
- R2: When search_start is high at a clock edge, then after that edge coarse_word is 128, restart_out is 1 and fine_mode is 0. This holds in every state, including mid-search and fine mode.
- R3: Each restart pulse holds restart_out high for exactly max(2, restart_cycles) consecutive cycles. After that, restart_out stays low until a decision is accepted.
- R4: A decision is accepted when decision_valid is high while restart_out is low and a search is in progress. After that edge, coarse_word has the current step added if decision_slow is 1, or subtracted if decision_slow is 0.
- R5: The steps of one search are applied in the order 64, 32, 16, 8, 4, 2, 1, 1.
- R6: After each of the first seven accepted decisions, a new restart pulse begins in the same cycle in which the word is updated.
- R7: After the eighth accepted decision, fine_mode is 1 from the next cycle and restart_out stays 0. coarse_word holds its value until search_start.
- R8: decision_valid has no effect on coarse_word, restart_out or fine_mode while restart_out is high, before the first search_start, or in fine mode.
- R9: The word saturates: an addition that would pass 255 gives 255, and a subtraction that would go below 0 gives 0.
- R10: If search_start and decision_valid are high at the same edge, the start wins. The word returns to 128 and a new pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| search_start | input | 1 | Launches a new search from mid-scale |
| decision_valid | input | 1 | Phase detector verdict strobe |
| decision_slow | input | 1 | Verdict: 1 = oscillator slow (add), 0 = fast (subtract) |
| restart_cycles | input | LEN_W (4) | Requested restart pulse length in cycles, values below 2 act as 2 |
| restart_out | output | 1 | Zero-phase restart to the oscillator/reference gating |
| coarse_word | output | WORD_W (8) | Accumulated coarse control word |
| fine_mode | output | 1 | High once the search has ended |

## Verification
Every output is a register, so each result appears one edge after the input that causes it. A start or an accepted verdict shows up on the word, the restart line and the mode flag right after that edge. The bench drives inputs on the falling edge and reads the outputs shortly after the next rising edge. For the pulse length, it counts the edges at which restart_out is high, from the start or verdict edge until the first low sample, and compares that count with max(2, restart_cycles). Ignored verdicts are checked the same way: one edge after the strobe the bench confirms that nothing moved, and it confirms this again once the pulse has ended.

// File: rtl/cs_coarse_pkg.sv
package cs_coarse_pkg;

  // Shortest restart pulse the oscillator gating can honour
  localparam int unsigned MIN_RESTART_CYCLES = 2;

  typedef enum logic [1:0] {
    CS_IDLE    = 2'd0,
    CS_RESTART = 2'd1,
    CS_DECIDE  = 2'd2,
    CS_FINE    = 2'd3
  } cs_state_e;

endpackage

// File: rtl/cs_step_seq.sv
// Walks the binary-search step list: halving powers of two, then a repeated 1.
module cs_step_seq #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  output logic [WORD_W-1:0] step,
  output logic              last
);
  localparam int NSTEPS = WORD_W;
  localparam int IDX_W  = $clog2(NSTEPS);

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] step_lut [NSTEPS];

  genvar g;
  generate
    for (g = 0; g < NSTEPS; g++) begin : g_step
      if (g < NSTEPS - 1) begin : g_pow
        assign step_lut[g] = WORD_W'(1) << (NSTEPS - 2 - g);
      end else begin : g_tail
        assign step_lut[g] = WORD_W'(1);
      end
    end
  endgenerate

  assign last = (idx_q == IDX_W'(NSTEPS - 1));
  assign step = step_lut[idx_q];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
    end else if (advance && !last) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/cs_accum.sv
// Saturating add/subtract accumulator that holds the coarse word.
module cs_accum #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mid,
  input  logic              update,
  input  logic              up,
  input  logic [WORD_W-1:0] step,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] MID  = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] FULL = '1;

  logic [WORD_W:0]   sum_ext;
  logic [WORD_W:0]   diff_ext;
  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    sum_ext  = {1'b0, word} + {1'b0, step};
    diff_ext = {1'b0, word} - {1'b0, step};
    if (up) begin
      word_nxt = sum_ext[WORD_W] ? FULL : sum_ext[WORD_W-1:0];
    end else begin
      word_nxt = diff_ext[WORD_W] ? '0 : diff_ext[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load_mid) begin
      word <= MID;
    end else if (update) begin
      word <= word_nxt;
    end
  end

endmodule

// File: rtl/cs_pulse.sv
// Restart pulse timer with a floor on the requested length.
module cs_pulse
  import cs_coarse_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             ending
);
  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_RESTART_CYCLES);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] reload;

  assign eff_len = (len < FLOOR) ? FLOOR : len;
  assign reload  = eff_len - LEN_W'(1);
  assign ending  = active && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (fire) begin
      active <= 1'b1;
      cnt_q  <= reload;
    end else if (active) begin
      if (cnt_q == '0) begin
        active <= 1'b0;
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/cs_coarse_tuner.sv
// Coarse tuning search controller: restart, await verdict, step the word.
module cs_coarse_tuner
  import cs_coarse_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              search_start,
  input  logic              decision_valid,
  input  logic              decision_slow,
  input  logic [LEN_W-1:0]  restart_cycles,
  output logic              restart_out,
  output logic [WORD_W-1:0] coarse_word,
  output logic              fine_mode
);
  cs_state_e         state_q, state_d;
  logic              take;
  logic              fire;
  logic              last_step;
  logic              pulse_end;
  logic [WORD_W-1:0] step;

  // A verdict counts only while waiting for one; start has priority (R10)
  assign take = (state_q == CS_DECIDE) && decision_valid && !search_start;
  assign fire = search_start || (take && !last_step);

  always_comb begin
    state_d = state_q;
    if (search_start) begin
      state_d = CS_RESTART;
    end else begin
      case (state_q)
        CS_RESTART: if (pulse_end) state_d = CS_DECIDE;
        CS_DECIDE:  if (decision_valid) state_d = last_step ? CS_FINE : CS_RESTART;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CS_IDLE;
      fine_mode <= 1'b0;
    end else begin
      state_q   <= state_d;
      fine_mode <= (state_d == CS_FINE);
    end
  end

  cs_step_seq #(.WORD_W(WORD_W)) u_steps (
    .clk     (clk),
    .rst     (rst),
    .clear   (search_start),
    .advance (take),
    .step    (step),
    .last    (last_step)
  );

  cs_accum #(.WORD_W(WORD_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .load_mid (search_start),
    .update   (take),
    .up       (decision_slow),
    .step     (step),
    .word     (coarse_word)
  );

  cs_pulse #(.LEN_W(LEN_W)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .len    (restart_cycles),
    .active (restart_out),
    .ending (pulse_end)
  );

endmodule

// File: rtl/cs_coarse_tuner_chk.sv
module cs_coarse_tuner_chk #(
  parameter int WORD_W = 8,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              search_start,
  input logic              decision_valid,
  input logic [WORD_W-1:0] coarse_word,
  input logic              restart_out,
  input logic              fine_mode
);
  localparam logic [WORD_W-1:0] MID = WORD_W'(1) << (WORD_W - 1);

  assert_start_relaunch_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(search_start)) |-> (restart_out && coarse_word == MID && !fine_mode));

  assert_pulse_min_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(restart_out)) |-> $past(restart_out, 2));

  assert_restart_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(restart_out)) |-> ($past(search_start) || $past(decision_valid)));

  assert_fine_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    fine_mode |-> !restart_out);

  assert_fine_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_mode) && !$past(search_start)) |-> (fine_mode && $stable(coarse_word)));

  assert_word_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(coarse_word)) |-> ($past(search_start) || $past(decision_valid)));

endmodule

bind cs_coarse_tuner cs_coarse_tuner_chk #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .search_start   (search_start),
  .decision_valid (decision_valid),
  .coarse_word    (coarse_word),
  .restart_out    (restart_out),
  .fine_mode      (fine_mode)
);

// File: tb/cs_coarse_tuner_test.sv
module cs_coarse_tuner_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 8;
  localparam int LEN_W  = 4;
  localparam int NVEC   = 6;
  // {restart length, verdicts first-step-in-bit-7, expected final word}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd0, 8'hFF, 8'd255},
    {4'd1, 8'h00, 8'd0},
    {4'd2, 8'hAA, 8'd170},
    {4'd3, 8'h55, 8'd86},
    {4'd5, 8'h01, 8'd2},
    {4'd4, 8'hFE, 8'd254}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic search_start = 1'b0;
  logic decision_valid = 1'b0;
  logic decision_slow = 1'b0;
  logic [LEN_W-1:0] restart_cycles = 4'd2;
  logic restart_out;
  logic [WORD_W-1:0] coarse_word;
  logic fine_mode;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_coarse_tuner #(.WORD_W(WORD_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .search_start(search_start),
    .decision_valid(decision_valid), .decision_slow(decision_slow),
    .restart_cycles(restart_cycles), .restart_out(restart_out),
    .coarse_word(coarse_word), .fine_mode(fine_mode)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int step_of(input int i);
    return (i < 7) ? (64 >> i) : 1;
  endfunction

  function automatic int eff_len(input int l);
    return (l < 2) ? 2 : l;
  endfunction

  // Start a search; samples once after the start edge
  task automatic launch(input int len);
    @(negedge clk);
    restart_cycles = LEN_W'(len);
    search_start = 1'b1;
    @(posedge clk); #1;
    check_eq("R2 word after start", coarse_word, 128);
    check_eq("R2 restart after start", restart_out, 1);
    check_eq("R2 fine after start", fine_mode, 0);
    @(negedge clk);
    search_start = 1'b0;
  endtask

  // Counts edges with restart high; one already seen by the caller
  task automatic pulse_len(output int n);
    n = 1;
    forever begin
      @(posedge clk); #1;
      if (!restart_out) break;
      n++;
    end
  endtask

  task automatic decide(input bit slow);
    @(negedge clk);
    decision_valid = 1'b1;
    decision_slow = slow;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check_eq("R1 reset word", coarse_word, 128);
    check_eq("R1 reset restart", restart_out, 0);
    check_eq("R1 reset fine", fine_mode, 0);

    // R8: verdict before any start is ignored
    decide(1'b1);
    @(negedge clk); decision_valid = 1'b0;
    check_eq("R8 idle word", coarse_word, 128);
    check_eq("R8 idle restart", restart_out, 0);

    // Table walk: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      launch(int'(VEC[v][19:16]));
      pulse_len(n);
      check_eq("R3 pulse length", n, eff_len(int'(VEC[v][19:16])));
      exp = 128;
      for (int i = 0; i < 8; i++) begin
        bit slow;
        slow = VEC[v][15 - i];
        decide(slow);
        exp = slow ? exp + step_of(i) : exp - step_of(i);
        if (exp > 255) exp = 255;
        if (exp < 0) exp = 0;
        check_eq("R4 R5 R9 word after verdict", coarse_word, exp);
        if (i < 7) begin
          check_eq("R6 new restart", restart_out, 1);
          check_eq("R6 not fine yet", fine_mode, 0);
        end else begin
          check_eq("R7 fine raised", fine_mode, 1);
          check_eq("R7 no restart", restart_out, 0);
        end
        @(negedge clk); decision_valid = 1'b0;
        if (i < 7) pulse_len(n);
      end
      check_eq("R9 table final word", coarse_word, int'(VEC[v][7:0]));
    end

    // R8: verdict in fine mode is ignored
    decide(1'b0);
    @(negedge clk); decision_valid = 1'b0;
    @(posedge clk); #1;
    check_eq("R8 fine word held", coarse_word, 254);
    check_eq("R8 fine kept", fine_mode, 1);
    check_eq("R8 fine no restart", restart_out, 0);

    // R2 from fine mode, then R8 verdict during restart
    launch(6);
    decide(1'b0);
    @(negedge clk); decision_valid = 1'b0;
    check_eq("R8 word during restart", coarse_word, 128);
    check_eq("R8 restart still high", restart_out, 1);
    pulse_len(n);
    check_eq("R8 word after restart", coarse_word, 128);
    decide(1'b1);
    check_eq("R4 first slow step", coarse_word, 192);
    @(negedge clk); decision_valid = 1'b0;
    pulse_len(n);
    check_eq("R3 len six", n, 6);
    decide(1'b0);
    check_eq("R5 second step fast", coarse_word, 160);
    @(negedge clk); decision_valid = 1'b0;

    // R2: relaunch while a restart pulse is running
    launch(6);
    pulse_len(n);
    check_eq("R3 relaunch pulse", n, 6);

    // R10: start and verdict together
    @(negedge clk);
    search_start = 1'b1;
    decision_valid = 1'b1;
    decision_slow = 1'b1;
    @(posedge clk); #1;
    check_eq("R10 word back to mid", coarse_word, 128);
    check_eq("R10 restart begun", restart_out, 1);
    @(negedge clk);
    search_start = 1'b0;
    decision_valid = 1'b0;
    pulse_len(n);
    check_eq("R10 full pulse", n, 6);
    decide(1'b1);
    check_eq("R10 first step restarts at 64", coarse_word, 192);
    @(negedge clk); decision_valid = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule